// File: doc/BRIEF.md
# Glitch-free system clock source switch

This block picks the system clock from three free-running inputs: a fast primary clock, a slow secondary oscillator clock and a postscaled internal clock. A 2-bit select register chooses the source. The register is written on the internal clock, which is the only clock the block expects to keep running.

A change of source never produces a runt pulse. The outgoing clock is gated off on its own falling edge. Only after that does the incoming clock's enable pass through a synchroniser in the new domain, and it is ungated on a falling edge of the new clock. The output stays low through the handover. During that window the old source runs for about two more cycles and the new source takes three to four cycles.

Two status flags tell software which source drives the output. When both flags are low, the internal clock is in use, or no source has yet been enabled.

Top module: `clk_src_switch`

## Requirements
- R1: The select code is decoded as follows: 2'b00 selects the primary clock, 2'b01 the secondary clock, and 2'b10 or 2'b11 the internal clock. Once a switch settles, `clk_out` has the period of the selected source.
- R2: Reset sets the select register to 2'b00 (primary) and clears both status flags. `clk_out` stays low while reset is held.
- R3: During a switch the old clock is gated off on its falling edge. The low time from that edge to the first rising edge of `clk_out` lasts at least 3 and at most 4 periods of the new clock. At most one source is ever gated through.
- R4: A write of 2'b01 is ignored while both `sec_en` and `sec_dig_ovr` are low. If either of them is high, the write is accepted.
- R5: `stat_pri` is high only while the primary clock drives the output and `pri_stable` is high.
- R6: `stat_sec` is high only while the secondary clock drives the output. `stat_pri` and `stat_sec` are never high together.
- R7: While the internal clock drives the output, both flags are low.
- R8: A write whose code maps to the source already in use causes no pause in `clk_out`.
- R9: A write that lands during a switch is held in the select register. It starts a new switch only after the current one has completed.
- R10: No high or low pulse on `clk_out` is shorter than half the period of the fastest source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pri | input | 1 | Primary clock |
| clk_sec | input | 1 | Secondary oscillator clock |
| clk_int | input | 1 | Postscaled internal clock; also clocks the select register |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_we | input | 1 | Select register write strobe (clk_int domain) |
| sel_wdata | input | 2 | Select code to write |
| sec_en | input | 1 | Secondary oscillator enabled |
| sec_dig_ovr | input | 1 | Accept secondary selection even when the oscillator is disabled |
| pri_stable | input | 1 | Primary start-up timer has expired |
| clk_out | output | 1 | Switched system clock |
| stat_pri | output | 1 | Primary clock drives the output and is stable |
| stat_sec | output | 1 | Secondary clock drives the output |

## Verification
The bench builds the block with its default parameters: a 3-stage turn-on chain, a 2-stage turn-off chain and a 2-stage status synchroniser. With these values the expected output gap is exactly three to four periods of the incoming clock. The three sources run at 14 ns, 46 ns and 20 ns periods, so the bench can walk all six ordered transitions, with the fast source and the slow source each on both sides of a switch. Each measured gap and each settled period is compared against the value computed from these periods.

// File: rtl/clk_src_switch.sv
module clk_src_switch #(
  parameter int ON_STAGES  = 3,
  parameter int OFF_STAGES = 2,
  parameter int CTRL_SYNC  = 2
) (
  input  logic       clk_pri,
  input  logic       clk_sec,
  input  logic       clk_int,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic [1:0] sel_wdata,
  input  logic       sec_en,
  input  logic       sec_dig_ovr,
  input  logic       pri_stable,
  output logic       clk_out,
  output logic       stat_pri,
  output logic       stat_sec
);
  localparam int NSRC = 3;

  logic [NSRC-1:0] clks, en, want;
  logic [1:0]      sel_q, tgt, sel_idx;
  logic [NSRC-1:0] en_sync [CTRL_SYNC];
  logic [NSRC-1:0] en_s;
  logic            wr_ok, done;

  assign clks    = {clk_int, clk_sec, clk_pri};
  assign sel_idx = sel_q[1] ? 2'd2 : {1'b0, sel_q[0]};
  assign wr_ok   = sel_we && !(sel_wdata == 2'b01 && !sec_en && !sec_dig_ovr);
  assign en_s    = en_sync[CTRL_SYNC-1];
  assign done    = (en_s == (NSRC'(1) << tgt));
  assign want    = NSRC'(1) << tgt;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 2'b00;
      tgt   <= 2'd0;
    end else begin
      if (wr_ok) sel_q <= sel_wdata;
      if (done && sel_idx != tgt) tgt <= sel_idx;
    end
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < CTRL_SYNC; k++) en_sync[k] <= '0;
    end else begin
      en_sync[0] <= en;
      for (int k = 1; k < CTRL_SYNC; k++) en_sync[k] <= en_sync[k-1];
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam logic [NSRC-1:0] SELF = NSRC'(1) << i;
    logic                 d;
    logic [ON_STAGES-1:0] chain;
    logic                 en_r;

    assign d = want[i] & ~|(en & ~SELF);

    always_ff @(posedge clks[i] or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[ON_STAGES-2:0], d};
    end

    always_ff @(negedge clks[i] or negedge rst_n) begin
      if (!rst_n) en_r <= 1'b0;
      else        en_r <= en_r ? chain[OFF_STAGES-1] : chain[ON_STAGES-1];
    end

    assign en[i] = en_r;
  end

  assign clk_out  = |(en & clks);
  assign stat_pri = en[0] & pri_stable;
  assign stat_sec = en[1];
endmodule

// File: rtl/clk_src_switch_chk.sv
module clk_src_switch_chk (
  input logic       clk_int,
  input logic       rst_n,
  input logic       sel_we,
  input logic [1:0] sel_wdata,
  input logic       sec_en,
  input logic       sec_dig_ovr,
  input logic [1:0] sel_q,
  input logic [1:0] tgt,
  input logic [2:0] en,
  input logic [2:0] en_s,
  input logic       stat_pri,
  input logic       stat_sec
);
  // R6
  flags_excl_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(stat_pri && stat_sec));

  // R3
  one_gate_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    $onehot0(en));

  // R4
  sec_ignore_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (sel_we && sel_wdata == 2'b01 && !sec_en && !sec_dig_ovr) |=> $stable(sel_q));

  // R9
  hold_tgt_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (en_s != (3'b001 << tgt)) |=> $stable(tgt));

  // R7
  int_flags_chk: assert property (@(posedge clk_int) disable iff (!rst_n)
    (tgt == 2'd2 && en_s == 3'b100 && $stable(en_s)) |-> (!stat_pri && !stat_sec));

  // R2
  always @(posedge clk_int)
    if (!rst_n) reset_sel_chk: assert (sel_q == 2'b00 && tgt == 2'd0);
endmodule

bind clk_src_switch clk_src_switch_chk u_chk (
  .clk_int(clk_int), .rst_n(rst_n), .sel_we(sel_we), .sel_wdata(sel_wdata),
  .sec_en(sec_en), .sec_dig_ovr(sec_dig_ovr), .sel_q(sel_q), .tgt(tgt),
  .en(en), .en_s(en_s), .stat_pri(stat_pri), .stat_sec(stat_sec)
);

// File: tb/sim_clk_src_switch.sv
`timescale 1ns/1ps
module sim_clk_src_switch;
  localparam real TP = 14.0, TS = 46.0, TI = 20.0;
  localparam real TFAST = 14.0, GAP_MIN = 24.0, EPS = 0.01;

  logic clk_pri = 0, clk_sec = 0, clk_int = 0, rst_n = 0;
  logic sel_we = 0, sec_en = 1, sec_dig_ovr = 0, pri_stable = 1;
  logic [1:0] sel_wdata = 2'b00;
  logic clk_out, stat_pri, stat_sec;

  int checks = 0, failures = 0, gap_cnt = 0, short_cnt = 0;
  real last_gap = 0.0, last_hi = 0.0, t_rise = 0.0, t_fall = 0.0;
  bit  fall_ok = 0, rise_ok = 0, finished = 0;

  always #(TP/2) clk_pri = ~clk_pri;
  always #(TS/2) clk_sec = ~clk_sec;
  always #(TI/2) clk_int = ~clk_int;

  clk_src_switch u0 (
    .clk_pri(clk_pri), .clk_sec(clk_sec), .clk_int(clk_int), .rst_n(rst_n),
    .sel_we(sel_we), .sel_wdata(sel_wdata), .sec_en(sec_en),
    .sec_dig_ovr(sec_dig_ovr), .pri_stable(pri_stable),
    .clk_out(clk_out), .stat_pri(stat_pri), .stat_sec(stat_sec)
  );

  // R10 pulse monitor and gap measurement
  always @(posedge clk_out) begin
    if (fall_ok) begin
      if ($realtime - t_fall > GAP_MIN) begin
        gap_cnt++;
        last_gap = $realtime - t_fall;
      end else if ($realtime - t_fall < TFAST/2 - EPS) short_cnt++;
    end
    t_rise = $realtime; rise_ok = 1;
  end
  always @(negedge clk_out) begin
    if (rise_ok) begin
      last_hi = $realtime - t_rise;
      if (last_hi < TFAST/2 - EPS) short_cnt++;
    end
    t_fall = $realtime; fall_ok = 1;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input real act, input real exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0.2f expected=%0.2f", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] code);
    @(negedge clk_int); sel_we = 1; sel_wdata = code;
    @(negedge clk_int); sel_we = 0;
  endtask

  task automatic settle();
    repeat (60) @(negedge clk_int);
  endtask

  function automatic real per(input int s);
    return (s == 0) ? TP : (s == 1) ? TS : TI;
  endfunction

  task automatic check_src(input int s, input string req);
    chk(last_hi > per(s)/2 - EPS && last_hi < per(s)/2 + EPS, req, "half period",
        last_hi, per(s)/2);
    chk(stat_pri == (s == 0), req, "stat_pri", real'(stat_pri), real'(s == 0));
    chk(stat_sec == (s == 1), req, "stat_sec", real'(stat_sec), real'(s == 1));
  endtask

  task automatic do_switch(input logic [1:0] code, input int s);
    gap_cnt = 0;
    wr(code);
    settle();
    chk(gap_cnt == 1, "R3", "gap count", real'(gap_cnt), 1.0);
    chk(last_gap >= 3*per(s) - EPS && last_gap <= 4*per(s) + EPS, "R3",
        "gap length", last_gap, 3.5*per(s));
    check_src(s, "R1");
  endtask

  task automatic report();
    chk(short_cnt == 0, "R10", "short pulses", real'(short_cnt), 0.0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      report();
    end
  end

  initial begin
    repeat (5) @(negedge clk_int);
    // R2 reset state
    chk(clk_out == 0, "R2", "clk_out in reset", real'(clk_out), 0.0);
    chk(!stat_pri && !stat_sec, "R2", "flags in reset", real'(stat_pri | stat_sec), 0.0);
    rst_n = 1;
    settle();
    check_src(0, "R2");

    // R8 same source
    gap_cnt = 0; wr(2'b00); settle();
    chk(gap_cnt == 0, "R8", "gap on same-source write", real'(gap_cnt), 0.0);

    // six transitions
    do_switch(2'b01, 1);
    do_switch(2'b10, 2);
    chk(!stat_pri && !stat_sec, "R7", "flags on internal", real'(stat_pri | stat_sec), 0.0);
    gap_cnt = 0; wr(2'b11); settle();
    chk(gap_cnt == 0, "R8", "alias 11 on internal", real'(gap_cnt), 0.0);
    check_src(2, "R1");
    do_switch(2'b00, 0);
    do_switch(2'b11, 2);
    do_switch(2'b01, 1);
    do_switch(2'b00, 0);

    // R5 primary not yet stable
    pri_stable = 0; @(negedge clk_int);
    chk(!stat_pri && !stat_sec, "R5", "flags with pri unstable", real'(stat_pri), 0.0);
    pri_stable = 1; @(negedge clk_int);
    chk(stat_pri, "R5", "stat_pri restored", real'(stat_pri), 1.0);

    // R4 secondary ignored when disabled
    sec_en = 0; sec_dig_ovr = 0;
    gap_cnt = 0; wr(2'b01); settle();
    chk(gap_cnt == 0, "R4", "gap on ignored write", real'(gap_cnt), 0.0);
    check_src(0, "R4");
    sec_dig_ovr = 1;
    do_switch(2'b01, 1);
    chk(stat_sec && !stat_pri, "R6", "secondary flag alone", real'(stat_sec), 1.0);
    sec_dig_ovr = 0; sec_en = 1;
    do_switch(2'b00, 0);

    // R9 write during a switch
    gap_cnt = 0;
    wr(2'b01);
    wr(2'b10);
    settle();
    chk(gap_cnt == 2, "R9", "two handovers", real'(gap_cnt), 2.0);
    check_src(2, "R9");

    finished = 1;
    report();
  end
endmodule